// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block runs one read access of a one-time-programmable fuse array without software toggling any pins. Software loads a timing window for each of the five array control lines: chip-select, program-enable, load, address and strobe. Each window gives the cycle at which the line turns on and the cycle at which it turns off, counted from the start of the access. Software then writes a start word that carries a word address and two launch bits. The sequencer plays out the waveforms and latches the 32-bit word on the array's data lines. When the access ends it sets a sticky finish flag, which software clears by writing a one.

A mode bit chooses between automatic sequencing and manual drive. In manual drive the array pins follow a register that software writes directly, and start requests are refused. Manual drive is the reset state, so the array sees chip-select and program-enable both high until software selects automatic mode. With the usual window settings an access lasts twelve controller cycles. At 250 MHz that is 48 ns, well inside the roughly 2 µs after which software polls the flag.

Register map (byte offsets on an 8-bit bus address, 32-bit data): mode 0x00, status 0x04, data 0x08, start 0x0C, manual 0x10, timing windows from 0x20 in steps of 4. The window order is chip-select, program-enable, load, address, strobe.

Top module: `fuse_rdseq`

## Requirements
- R1: After reset the pins are idle: fuse_cs_n=1, fuse_pgen_n=1, fuse_load=0, fuse_strobe=0 and fuse_addr=0. Status (0x04) reads 0 and mode (0x00) reads 1.
- R2: A timing window register holds the on cycle in bits 31:16 and the off cycle in bits 15:0. Cycle 0 is the first cycle after the clock edge that accepts the start write. A line is active in every cycle k with on <= k < off.
- R3: The start register (0x0C) carries the word address in bits 25:16. Bit 0 is the enable bit and bit 1 is the read bit. An access launches only when both bits are 1 and mode bit 0 is 0; any other write to it is ignored.
- R4: The fuse data lines are sampled at the end of the cycle whose count equals the strobe off cycle, and the sample is readable at 0x08. The access ends in the cycle whose count equals the largest off cycle of the five windows. In the next cycle status bit 1 (busy) is 0 and status bit 0 (finish) is 1.
- R5: The finish flag stays set until software writes status with bit 0 = 1. A write with bit 0 = 0 leaves it set.
- R6: While busy, start writes and writes to the mode and timing registers are ignored. The access in flight keeps its address and its waveforms.
- R7: When all timing windows are zero, an access is busy for exactly one cycle and then finishes, with every pin inactive throughout.
- R8: With mode bit 0 = 1 the pins follow the manual register (0x10) in the cycle after it is written. The fields are: bit 0 chip-select (low active), bit 1 program-enable (low active), bit 2 load, bit 3 strobe, and bits 25:16 address.
- R9: In automatic mode, chip-select and program-enable are driven low while active and high otherwise. Load and strobe are driven high while active. fuse_addr carries the latched word address only while the address window is active, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | BAW | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| fuse_dout | input | DW | Data lines from the fuse array |
| fuse_cs_n | output | 1 | Array chip-select, low active |
| fuse_pgen_n | output | 1 | Array program-enable, low active |
| fuse_load | output | 1 | Array load |
| fuse_strobe | output | 1 | Array read strobe |
| fuse_addr | output | AW | Array word address |

## Verification
A wrong cycle counter or a wrong window compare shows on the array pins in the same cycle as the error. For that reason the pins are compared against the programmed windows on every cycle of several accesses. A capture taken in the wrong cycle shows only in the data register after the access. The bench therefore changes the fuse data lines every cycle, so that the latched word identifies the cycle it came from. A lost or stuck busy state shows in the status bits one cycle after the expected end. A start or mode write that leaks through during an access would alter the address pins or the mode readback within a cycle, so both are checked.

// File: rtl/fuse_rdseq_pkg.sv
package fuse_rdseq_pkg;
  localparam int NSIG     = 5;
  localparam int CW       = 16;
  localparam int ADDR_LSB = 16;
  localparam int BIT_EN   = 0;
  localparam int BIT_RD   = 1;

  localparam int OFS_MODE  = 'h00;
  localparam int OFS_STAT  = 'h04;
  localparam int OFS_DATA  = 'h08;
  localparam int OFS_START = 'h0C;
  localparam int OFS_MAN   = 'h10;
  localparam int OFS_TIM0  = 'h20;

  typedef enum int {
    SIG_CS   = 0,
    SIG_PGEN = 1,
    SIG_LOAD = 2,
    SIG_ADDR = 3,
    SIG_STRB = 4
  } sig_e;

  typedef struct packed {
    logic [CW-1:0] on_cyc;
    logic [CW-1:0] off_cyc;
  } win_t;

  typedef struct packed {
    logic strobe;
    logic load;
    logic pgen_n;
    logic cs_n;
  } man_t;
endpackage

// File: rtl/fuse_rdseq_regs.sv
module fuse_rdseq_regs
  import fuse_rdseq_pkg::*;
#(
  parameter int AW  = 10,
  parameter int DW  = 32,
  parameter int BAW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [BAW-1:0]        bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic                  busy_q,
  input  logic                  seq_fin,
  input  logic                  seq_cap,
  input  logic [DW-1:0]         fuse_dout,
  output logic                  mode_q,
  output logic                  done_q,
  output logic                  start_go,
  output logic [AW-1:0]         addr_q,
  output win_t [NSIG-1:0]       win_q,
  output man_t                  man_q,
  output logic [AW-1:0]         man_addr_q
);
  logic            hit_mode, hit_stat, hit_start, hit_man;
  logic [NSIG-1:0] hit_tim;
  logic            mode_n, done_n;
  logic [AW-1:0]   addr_n, man_addr_n;
  logic [DW-1:0]   data_q, data_n;
  win_t [NSIG-1:0] win_n;
  man_t            man_n;

  always_comb begin
    hit_mode  = bus_we && (bus_addr == BAW'(OFS_MODE));
    hit_stat  = bus_we && (bus_addr == BAW'(OFS_STAT));
    hit_start = bus_we && (bus_addr == BAW'(OFS_START));
    hit_man   = bus_we && (bus_addr == BAW'(OFS_MAN));
    for (int i = 0; i < NSIG; i++) begin
      hit_tim[i] = bus_we && (bus_addr == BAW'(OFS_TIM0 + 4 * i));
    end
    start_go = hit_start && bus_wdata[BIT_EN] && bus_wdata[BIT_RD] && !mode_q && !busy_q;
  end

  // next-state
  always_comb begin
    mode_n     = (hit_mode && !busy_q) ? bus_wdata[0] : mode_q;
    done_n     = seq_fin ? 1'b1 : ((hit_stat && bus_wdata[0]) ? 1'b0 : done_q);
    addr_n     = start_go ? bus_wdata[ADDR_LSB +: AW] : addr_q;
    data_n     = seq_cap ? fuse_dout : data_q;
    man_n      = hit_man ? man_t'(bus_wdata[3:0]) : man_q;
    man_addr_n = hit_man ? bus_wdata[ADDR_LSB +: AW] : man_addr_q;
    for (int i = 0; i < NSIG; i++) begin
      win_n[i] = (hit_tim[i] && !busy_q) ? win_t'(bus_wdata) : win_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= 1'b1;
      done_q     <= 1'b0;
      addr_q     <= '0;
      data_q     <= '0;
      man_q      <= '{strobe: 1'b0, load: 1'b0, pgen_n: 1'b1, cs_n: 1'b1};
      man_addr_q <= '0;
      win_q      <= '0;
    end else begin
      mode_q     <= mode_n;
      done_q     <= done_n;
      addr_q     <= addr_n;
      data_q     <= data_n;
      man_q      <= man_n;
      man_addr_q <= man_addr_n;
      win_q      <= win_n;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == BAW'(OFS_MODE)) begin
      bus_rdata[0] = mode_q;
    end else if (bus_addr == BAW'(OFS_STAT)) begin
      bus_rdata[1:0] = {busy_q, done_q};
    end else if (bus_addr == BAW'(OFS_DATA)) begin
      bus_rdata = 32'(data_q);
    end else if (bus_addr == BAW'(OFS_MAN)) begin
      bus_rdata[3:0]               = man_q;
      bus_rdata[ADDR_LSB +: AW]    = man_addr_q;
    end else begin
      for (int i = 0; i < NSIG; i++) begin
        if (bus_addr == BAW'(OFS_TIM0 + 4 * i)) bus_rdata = win_q[i];
      end
    end
  end
endmodule

// File: rtl/fuse_rdseq_seq.sv
module fuse_rdseq_seq
  import fuse_rdseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_go,
  input  win_t [NSIG-1:0] win_q,
  output logic            busy_q,
  output logic            busy_n,
  output logic [CW-1:0]   cnt_q,
  output logic [CW-1:0]   cnt_n,
  output logic            seq_fin,
  output logic            seq_cap
);
  logic [CW-1:0] last_cyc;

  always_comb begin
    last_cyc = '0;
    for (int i = 0; i < NSIG; i++) begin
      if (win_q[i].off_cyc > last_cyc) last_cyc = win_q[i].off_cyc;
    end
    seq_fin = busy_q && (cnt_q == last_cyc);
    seq_cap = busy_q && (cnt_q == win_q[SIG_STRB].off_cyc);
  end

  // next-state
  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    if (start_go) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (seq_fin) begin
      busy_n = 1'b0;
    end else if (busy_q) begin
      cnt_n  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end
endmodule

// File: rtl/fuse_rdseq_wave.sv
module fuse_rdseq_wave
  import fuse_rdseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy_n,
  input  logic [CW-1:0]   cnt_n,
  input  win_t [NSIG-1:0] win_q,
  output logic [NSIG-1:0] act_q
);
  logic [NSIG-1:0] act_n;

  for (genvar g = 0; g < NSIG; g++) begin : g_sig
    assign act_n[g] = busy_n && (cnt_n >= win_q[g].on_cyc) && (cnt_n < win_q[g].off_cyc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_n;
  end
endmodule

// File: rtl/fuse_rdseq.sv
module fuse_rdseq
  import fuse_rdseq_pkg::*;
#(
  parameter int AW  = 10,
  parameter int DW  = 32,
  parameter int BAW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [BAW-1:0] bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic [DW-1:0]  fuse_dout,
  output logic           fuse_cs_n,
  output logic           fuse_pgen_n,
  output logic           fuse_load,
  output logic           fuse_strobe,
  output logic [AW-1:0]  fuse_addr
);
  logic            rst_meta_n, rst_sync_n;
  logic            mode_q, done_q, start_go;
  logic            busy_q, busy_n, seq_fin, seq_cap;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [AW-1:0]   addr_q, man_addr_q;
  win_t [NSIG-1:0] win_q;
  man_t            man_q;
  logic [NSIG-1:0] act_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  fuse_rdseq_regs #(.AW(AW), .DW(DW), .BAW(BAW)) regs_i (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy_q(busy_q), .seq_fin(seq_fin), .seq_cap(seq_cap), .fuse_dout(fuse_dout),
    .mode_q(mode_q), .done_q(done_q), .start_go(start_go), .addr_q(addr_q),
    .win_q(win_q), .man_q(man_q), .man_addr_q(man_addr_q)
  );

  fuse_rdseq_seq seq_i (
    .clk(clk), .rst_n(rst_sync_n), .start_go(start_go), .win_q(win_q),
    .busy_q(busy_q), .busy_n(busy_n), .cnt_q(cnt_q), .cnt_n(cnt_n),
    .seq_fin(seq_fin), .seq_cap(seq_cap)
  );

  fuse_rdseq_wave wave_i (
    .clk(clk), .rst_n(rst_sync_n), .busy_n(busy_n), .cnt_n(cnt_n),
    .win_q(win_q), .act_q(act_q)
  );

  // pin select between manual register and sequenced windows
  always_comb begin
    if (mode_q) begin
      fuse_cs_n   = man_q.cs_n;
      fuse_pgen_n = man_q.pgen_n;
      fuse_load   = man_q.load;
      fuse_strobe = man_q.strobe;
      fuse_addr   = man_addr_q;
    end else begin
      fuse_cs_n   = !act_q[SIG_CS];
      fuse_pgen_n = !act_q[SIG_PGEN];
      fuse_load   = act_q[SIG_LOAD];
      fuse_strobe = act_q[SIG_STRB];
      fuse_addr   = act_q[SIG_ADDR] ? addr_q : '0;
    end
  end
endmodule

// File: rtl/fuse_rdseq_chk.sv
module fuse_rdseq_chk
  import fuse_rdseq_pkg::*;
#(
  parameter int AW  = 10,
  parameter int BAW = 8
) (
  input logic           clk,
  input logic           rst_sync_n,
  input logic           mode_q,
  input logic           busy_q,
  input logic           done_q,
  input logic [AW-1:0]  addr_q,
  input logic           bus_we,
  input logic [BAW-1:0] bus_addr,
  input logic [31:0]    bus_wdata,
  input logic           fuse_cs_n,
  input logic           fuse_pgen_n,
  input logic           fuse_load,
  input logic           fuse_strobe,
  input logic [AW-1:0]  fuse_addr
);
  // R9: automatic mode with no access in flight leaves every pin inactive
  a_r9_idle_pins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mode_q && !busy_q) |-> (fuse_cs_n && fuse_pgen_n && !fuse_load && !fuse_strobe && fuse_addr == '0));

  // R5: finish flag only clears on a one written to status bit 0
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_q && !(bus_we && bus_addr == BAW'(OFS_STAT) && bus_wdata[0])) |=> done_q);

  // R6: the address of an access in flight never changes
  a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_q |=> $stable(addr_q));

  // R8: no automatic access runs while manual drive is selected
  a_r8_no_auto_in_manual: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_q |-> !mode_q);

  // R4: the end of an access raises the finish flag
  a_r4_end_sets_done: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(busy_q) |-> done_q);

  // R3: an access starts only from a start write with both launch bits
  a_r3_start_bits: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy_q) |-> $past(bus_we && bus_addr == BAW'(OFS_START) && bus_wdata[0] && bus_wdata[1] && !mode_q));
endmodule

bind fuse_rdseq fuse_rdseq_chk #(.AW(AW), .BAW(BAW)) chk_i (
  .clk(clk), .rst_sync_n(rst_sync_n), .mode_q(mode_q), .busy_q(busy_q), .done_q(done_q),
  .addr_q(addr_q), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .fuse_cs_n(fuse_cs_n), .fuse_pgen_n(fuse_pgen_n), .fuse_load(fuse_load),
  .fuse_strobe(fuse_strobe), .fuse_addr(fuse_addr)
);

// File: tb/fuse_rdseq_tb_top.sv
`timescale 1ns/1ps
module fuse_rdseq_tb_top;
  localparam int AW = 10, DW = 32, BAW = 8;
  localparam logic [7:0] A_MODE = 8'h00, A_STAT = 8'h04, A_DATA = 8'h08,
                         A_START = 8'h0C, A_MAN = 8'h10, A_TIM0 = 8'h20;

  logic clk, rst_n, bus_we;
  logic [BAW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [DW-1:0] fuse_dout;
  logic fuse_cs_n, fuse_pgen_n, fuse_load, fuse_strobe;
  logic [AW-1:0] fuse_addr;

  int checks = 0, failures = 0;
  int ton[5], toff[5];

  fuse_rdseq #(.AW(AW), .DW(DW), .BAW(BAW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .fuse_dout(fuse_dout), .fuse_cs_n(fuse_cs_n),
    .fuse_pgen_n(fuse_pgen_n), .fuse_load(fuse_load), .fuse_strobe(fuse_strobe),
    .fuse_addr(fuse_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] pat(input int k);
    return 32'h5A000000 + 32'(k) * 32'h00010203;
  endfunction

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic check_pins(input string tag, input logic cs_n, input logic pg_n,
                            input logic ld, input logic st, input logic [AW-1:0] ad);
    check_eq({tag, " cs_n"}, 32'(fuse_cs_n), 32'(cs_n));
    check_eq({tag, " pgen_n"}, 32'(fuse_pgen_n), 32'(pg_n));
    check_eq({tag, " load"}, 32'(fuse_load), 32'(ld));
    check_eq({tag, " strobe"}, 32'(fuse_strobe), 32'(st));
    check_eq({tag, " addr"}, 32'(fuse_addr), 32'(ad));
  endtask

  function automatic bit act(input int i, input int k);
    return (ton[i] <= k) && (k < toff[i]);
  endfunction

  // R2 R4 R9: one access, pins compared every cycle against the windows
  task automatic run_access(input logic [AW-1:0] wa, input int inj_k, input logic [7:0] inj_a,
                            input logic [31:0] inj_d, input string tag);
    int last;
    logic [31:0] rd;
    last = 0;
    for (int i = 0; i < 5; i++) begin
      bus_write(A_TIM0 + 8'(4 * i), {ton[i][15:0], toff[i][15:0]});
      if (toff[i] > last) last = toff[i];
    end
    bus_write(A_STAT, 32'h1);
    bus_we = 1'b1; bus_addr = A_START; bus_wdata = (32'(wa) << 16) | 32'h3;
    @(posedge clk);
    for (int k = 0; k <= last; k++) begin
      @(negedge clk);
      bus_we = 1'b0;
      fuse_dout = pat(k);
      check_pins($sformatf("%s R2 R9 cycle %0d", tag, k), !act(0, k), !act(1, k), act(2, k),
                 act(4, k), act(3, k) ? wa : '0);
      if (k == 0) begin
        bus_read(A_STAT, rd);
        check_eq({tag, " R4 busy during access"}, rd, 32'h2);
      end
      if (k == inj_k) begin
        bus_we = 1'b1; bus_addr = inj_a; bus_wdata = inj_d;
      end
      @(posedge clk);
    end
    @(negedge clk);
    bus_we = 1'b0;
    bus_read(A_STAT, rd);
    check_eq({tag, " R4 finish status"}, rd, 32'h1);
    bus_read(A_DATA, rd);
    check_eq({tag, " R4 captured word"}, rd, pat(toff[4]));
  endtask

  task automatic set_typical();
    ton[0] = 0; toff[0] = 11;
    ton[1] = 0; toff[1] = 11;
    ton[2] = 0; toff[2] = 11;
    ton[3] = 2; toff[3] = 10;
    ton[4] = 5; toff[4] = 8;
  endtask

  task automatic t_reset();
    logic [31:0] rd;
    check_pins("R1 reset", 1'b1, 1'b1, 1'b0, 1'b0, '0);
    bus_read(A_STAT, rd);
    check_eq("R1 status after reset", rd, 32'h0);
    bus_read(A_MODE, rd);
    check_eq("R1 mode after reset", rd, 32'h1);
  endtask

  task automatic t_typical();
    bus_write(A_MODE, 32'h0);
    set_typical();
    run_access(10'h2A5, -1, 8'h0, 32'h0, "typical");
  endtask

  task automatic t_alt();
    ton[0] = 1; toff[0] = 9;
    ton[1] = 0; toff[1] = 9;
    ton[2] = 0; toff[2] = 8;
    ton[3] = 1; toff[3] = 7;
    ton[4] = 3; toff[4] = 6;
    run_access(10'h003, -1, 8'h0, 32'h0, "alt");
  endtask

  task automatic t_w1c();
    logic [31:0] rd;
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, rd);
    check_eq("R5 zero write keeps finish", rd, 32'h1);
    repeat (3) @(negedge clk);
    bus_read(A_STAT, rd);
    check_eq("R5 finish held", rd, 32'h1);
    bus_write(A_STAT, 32'h1);
    bus_read(A_STAT, rd);
    check_eq("R5 one write clears finish", rd, 32'h0);
  endtask

  task automatic t_busy_start();
    logic [31:0] rd;
    set_typical();
    run_access(10'h2A5, 3, A_START, (32'h111 << 16) | 32'h3, "R6 restart");
    repeat (2) @(negedge clk);
    bus_read(A_STAT, rd);
    check_eq("R6 no second access", rd, 32'h1);
  endtask

  task automatic t_busy_mode();
    logic [31:0] rd;
    set_typical();
    run_access(10'h0F0, 4, A_MODE, 32'h1, "R6 mode write");
    bus_read(A_MODE, rd);
    check_eq("R6 R8 mode write while busy ignored", rd, 32'h0);
  endtask

  task automatic t_bad_start();
    logic [31:0] rd;
    bus_write(A_STAT, 32'h1);
    bus_write(A_START, (32'h0AA << 16) | 32'h1);
    @(negedge clk);
    bus_read(A_STAT, rd);
    check_eq("R3 enable only ignored", rd, 32'h0);
    check_eq("R3 cs_n idle", 32'(fuse_cs_n), 32'h1);
    bus_write(A_START, (32'h0AA << 16) | 32'h2);
    @(negedge clk);
    bus_read(A_STAT, rd);
    check_eq("R3 read only ignored", rd, 32'h0);
  endtask

  task automatic t_zero();
    for (int i = 0; i < 5; i++) begin
      ton[i] = 0; toff[i] = 0;
    end
    run_access(10'h3FF, -1, 8'h0, 32'h0, "R7 zero windows");
  endtask

  task automatic t_manual();
    logic [31:0] rd;
    bus_write(A_MODE, 32'h1);
    bus_write(A_MAN, (32'h155 << 16) | 32'hE);
    check_pins("R8 manual drive", 1'b0, 1'b1, 1'b1, 1'b1, 10'h155);
    bus_write(A_STAT, 32'h1);
    set_typical();
    bus_write(A_START, (32'h001 << 16) | 32'h3);
    @(negedge clk);
    bus_read(A_STAT, rd);
    check_eq("R3 R8 start refused in manual", rd, 32'h0);
    check_pins("R8 pins kept", 1'b0, 1'b1, 1'b1, 1'b1, 10'h155);
    bus_write(A_MAN, 32'h3);
    check_pins("R8 manual idle", 1'b1, 1'b1, 1'b0, 1'b0, '0);
    bus_write(A_MODE, 32'h0);
    check_pins("R9 back to auto idle", 1'b1, 1'b1, 1'b0, 1'b0, '0);
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; fuse_dout = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_typical();
    t_w1c();
    t_alt();
    t_busy_start();
    t_busy_mode();
    t_bad_start();
    t_zero();
    t_manual();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule